// File: doc/BRIEF.md
# Multichannel Conversion Sequencer with Result Ring

This block runs a sequence of single-channel conversions on an external converter core, one request at a time, and stores each 16-bit result in a ring of eight result registers. A sequence begins from a host write pulse or from an external trigger pin. The trigger can respond to a rising edge or to a level. Each conversion request carries a channel number. In multi-channel mode the channel steps upward after every conversion and wraps from 7 to 0. With multi-channel mode off, every conversion uses the start channel.

A conversion counter selects which ring register receives the next result. With ring-persist mode off, the counter returns to 0 at every start. With ring-persist mode on, the counter continues from where the previous sequence left it, so results fill the ring circularly across sequences. The block keeps one valid flag for each ring register and one sequence-complete flag. The host clears these flags in one of three ways: by starting a new sequence, by a write-1-to-clear pulse, or by reading a result register. Whether a plain result read is enough depends on the fast-clear setting.

The converter interface is two valid/ready channels. The request channel (`req_valid`/`req_ready`/`req_ch`) holds `req_valid` and `req_ch` steady until the core accepts them. The result channel (`res_valid`/`res_ready`/`res_data`) raises `res_ready` only while one accepted request is waiting for its result. The core may hold `res_valid` as long as it needs to. `conv_abort` tells the core to drop its outstanding conversion.

Top module: `conv_seq_ring`

## Requirements
- R1: With `cfg_multi`=1 the channel of each request is one more than the channel of the previous request in the same sequence, modulo 8. For example, start 6 with length 5 gives the channels 6, 7, 0, 1, 2. With `cfg_multi`=0 every request uses `cfg_start_ch`.
- R2: A sequence issues exactly `cfg_len` conversions. A length code of 0 means 8 conversions.
- R3: With `cfg_fifo`=0 a start sets `conv_cnt` to 0. The k-th result of the sequence (counting from 0) is stored in register k.
- R4: With `cfg_fifo`=1 a start leaves `conv_cnt` unchanged. Each stored result goes to register `conv_cnt`, and the counter then increments, wrapping from 7 to 0.
- R5: A `wr_start` pulse aborts any sequence in progress and starts a new one. It clears `seq_done` and every bit of `res_flags` in the next cycle. It discards an outstanding result, and it raises `conv_abort` in the same cycle if a request has been accepted but its result has not yet been taken. Any start, including one from the trigger, clears the flags.
- R6: `seq_done` and the valid flag of the register written are both visible in the cycle after the last result handshake, and `busy` falls at the same edge.
- R7: A `clr_w1c` pulse clears each flag whose `clr_mask` bit is 1. Bit 8 is `seq_done` and bit k is the valid flag of register k. Flags whose mask bit is 0 are unchanged.
- R8: With `cfg_fast_clr`=0, a `rd_result` pulse clears flag `rd_idx` only if a `rd_status` pulse came before it, and that result read uses up the armed state. With `cfg_fast_clr`=1, a `rd_result` pulse alone clears the flag.
- R9: With `cfg_trig_en`=1 and `cfg_trig_level`=0, a rising edge on `trig_in` while idle starts one sequence. Holding `trig_in` high afterwards starts nothing more.
- R10: With `cfg_trig_en`=1 and `cfg_trig_level`=1, a new sequence starts on each idle cycle while `trig_in` is high, so sequences repeat until the level drops.
- R11: `req_valid` and `req_ch` stay stable until `req_ready`. `req_valid` and `res_ready` are never high together.
- R12: After reset, `busy`, `seq_done`, `res_flags`, `conv_cnt`, `req_valid` and `res_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start_ch | input | 3 | First channel of a sequence |
| cfg_len | input | 3 | Conversions per sequence, 0 means 8 |
| cfg_multi | input | 1 | Step the channel after each conversion |
| cfg_fifo | input | 1 | Keep the ring counter across starts |
| cfg_fast_clr | input | 1 | A result read alone clears its flag |
| cfg_trig_en | input | 1 | Allow the trigger pin to start sequences |
| cfg_trig_level | input | 1 | 1 = level trigger, 0 = rising-edge trigger |
| wr_start | input | 1 | Host start pulse, aborts and restarts |
| clr_w1c | input | 1 | Write-1-to-clear strobe |
| clr_mask | input | 9 | Flags to clear, bit 8 = seq_done |
| rd_status | input | 1 | Host status read strobe |
| rd_result | input | 1 | Host result read strobe |
| rd_idx | input | 3 | Ring register being read |
| rd_data | output | 16 | Contents of ring register rd_idx |
| trig_in | input | 1 | External trigger |
| req_valid | output | 1 | Conversion request valid |
| req_ready | input | 1 | Core accepts the request |
| req_ch | output | 3 | Channel for the request |
| conv_abort | output | 1 | Drop the outstanding conversion |
| res_valid | input | 1 | Core result valid |
| res_ready | output | 1 | Sequencer awaits a result |
| res_data | input | 16 | Conversion result |
| busy | output | 1 | A sequence is running |
| seq_done | output | 1 | Sequence-complete flag |
| res_flags | output | 8 | Per-register valid flags |
| conv_cnt | output | 3 | Ring register for the next result |

## Verification
The assertions check several rules on every clock cycle. They check the request hold and the single outstanding request of R11. They check the channel step after each accepted result, and the counter increment and flag set after each write. They check that `seq_done` rises only after a result handshake and that a host start clears every flag. Only the bench scenarios can show the full channel orders with wrap, the length-0 case, and the ring destinations with the counter either reset or kept. The same applies to the status-then-result clear rule, to abort with a new configuration, and to the difference between edge and level triggers.

// File: rtl/conv_seq_pkg.sv
`timescale 1ns/1ps
package conv_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } sq_state_e;
endpackage

// File: rtl/seq_trig.sv
`timescale 1ns/1ps
module seq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic trig_en,
  input  logic trig_level,
  input  logic idle,
  output logic trig_start
);
  logic trig_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_prev <= 1'b0;
    else        trig_prev <= trig_in;
  end

  // edge mode sees the rise only once; level mode re-fires on every idle cycle
  always_comb begin
    if (!trig_en || !idle) trig_start = 1'b0;
    else if (trig_level)   trig_start = trig_in;
    else                   trig_start = trig_in && !trig_prev;
  end
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
module seq_ctrl
  import conv_seq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int IDX_W = 3,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH_W-1:0]  cfg_start_ch,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_multi,
  input  logic             cfg_fifo,
  input  logic             wr_start,
  input  logic             trig_start,
  input  logic             req_ready,
  input  logic             res_valid,
  output logic             req_valid,
  output logic [CH_W-1:0]  req_ch,
  output logic             res_ready,
  output logic             conv_abort,
  output logic             start_fire,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             done_set,
  output logic             busy,
  output logic             multi_lat,
  output logic [IDX_W-1:0] conv_cnt
);
  localparam int RW     = LEN_W + 1;
  localparam int MAXLEN = 1 << LEN_W;

  sq_state_e        state;
  logic [CH_W-1:0]  ch_q;
  logic [RW-1:0]    remain_q;
  logic [IDX_W-1:0] cnt_q;
  logic             multi_q;
  logic             accept;
  logic             last;
  logic [RW-1:0]    len_load;

  always_comb begin
    start_fire = wr_start || trig_start;
    accept     = (state == SQ_WAIT) && res_valid && !wr_start;
    last       = (remain_q == RW'(1));
    len_load   = (cfg_len == '0) ? RW'(MAXLEN) : {1'b0, cfg_len};
    req_valid  = (state == SQ_REQ);
    res_ready  = (state == SQ_WAIT);
    busy       = (state != SQ_IDLE);
    conv_abort = wr_start && (state == SQ_WAIT);
    wr_en      = accept;
    wr_idx     = cnt_q;
    done_set   = accept && last;
    req_ch     = ch_q;
    conv_cnt   = cnt_q;
    multi_lat  = multi_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      ch_q     <= '0;
      remain_q <= '0;
      cnt_q    <= '0;
      multi_q  <= 1'b0;
    end else if (start_fire) begin
      state    <= SQ_REQ;
      ch_q     <= cfg_start_ch;
      remain_q <= len_load;
      multi_q  <= cfg_multi;
      if (!cfg_fifo) cnt_q <= '0;
    end else begin
      unique case (state)
        SQ_REQ:  if (req_ready) state <= SQ_WAIT;
        SQ_WAIT: if (accept) begin
          cnt_q    <= cnt_q + 1'b1;
          remain_q <= remain_q - 1'b1;
          if (multi_q) ch_q <= ch_q + 1'b1;
          state    <= last ? SQ_IDLE : SQ_REQ;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/result_bank.sv
`timescale 1ns/1ps
module result_bank #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clear_all,
  input  logic              done_set,
  input  logic              clr_w1c,
  input  logic [(1<<IDX_W):0] clr_mask,
  input  logic              rd_status,
  input  logic              rd_result,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              fast_clr,
  output logic [DATA_W-1:0] rd_data,
  output logic [(1<<IDX_W)-1:0] flags,
  output logic              seq_done
);
  localparam int NREG = 1 << IDX_W;

  logic [DATA_W-1:0] ent [NREG];
  logic              armed_q;
  logic              rd_clr_ok;

  assign rd_clr_ok = rd_result && (fast_clr || armed_q);

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic [DATA_W-1:0] data_q;
    logic              flag_q;
    logic              hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q <= '0;
        flag_q <= 1'b0;
      end else begin
        if (hit) data_q <= wr_data;
        if (hit)
          flag_q <= 1'b1;
        else if (clear_all || (clr_w1c && clr_mask[g]) ||
                 (rd_clr_ok && rd_idx == IDX_W'(g)))
          flag_q <= 1'b0;
      end
    end
    assign ent[g]   = data_q;
    assign flags[g] = flag_q;
  end

  assign rd_data = ent[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      seq_done <= 1'b0;
    end else begin
      if (rd_status)      armed_q <= 1'b1;
      else if (rd_result) armed_q <= 1'b0;
      if (done_set)
        seq_done <= 1'b1;
      else if (clear_all || (clr_w1c && clr_mask[NREG]))
        seq_done <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_seq_ring.sv
`timescale 1ns/1ps
module conv_seq_ring #(
  parameter int CH_W   = 3,
  parameter int IDX_W  = 3,
  parameter int LEN_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CH_W-1:0]        cfg_start_ch,
  input  logic [LEN_W-1:0]       cfg_len,
  input  logic                   cfg_multi,
  input  logic                   cfg_fifo,
  input  logic                   cfg_fast_clr,
  input  logic                   cfg_trig_en,
  input  logic                   cfg_trig_level,
  input  logic                   wr_start,
  input  logic                   clr_w1c,
  input  logic [(1<<IDX_W):0]    clr_mask,
  input  logic                   rd_status,
  input  logic                   rd_result,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   trig_in,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic [CH_W-1:0]        req_ch,
  output logic                   conv_abort,
  input  logic                   res_valid,
  output logic                   res_ready,
  input  logic [DATA_W-1:0]      res_data,
  output logic                   busy,
  output logic                   seq_done,
  output logic [(1<<IDX_W)-1:0]  res_flags,
  output logic [IDX_W-1:0]       conv_cnt
);
  logic             trig_start;
  logic             start_fire;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             done_set;
  logic             multi_lat;

  seq_trig u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_en(cfg_trig_en),
    .trig_level(cfg_trig_level), .idle(!busy), .trig_start(trig_start)
  );

  seq_ctrl #(.CH_W(CH_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_start_ch(cfg_start_ch), .cfg_len(cfg_len),
    .cfg_multi(cfg_multi), .cfg_fifo(cfg_fifo), .wr_start(wr_start),
    .trig_start(trig_start), .req_ready(req_ready), .res_valid(res_valid),
    .req_valid(req_valid), .req_ch(req_ch), .res_ready(res_ready),
    .conv_abort(conv_abort), .start_fire(start_fire), .wr_en(wr_en),
    .wr_idx(wr_idx), .done_set(done_set), .busy(busy),
    .multi_lat(multi_lat), .conv_cnt(conv_cnt)
  );

  result_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(res_data), .clear_all(start_fire), .done_set(done_set),
    .clr_w1c(clr_w1c), .clr_mask(clr_mask), .rd_status(rd_status),
    .rd_result(rd_result), .rd_idx(rd_idx), .fast_clr(cfg_fast_clr),
    .rd_data(rd_data), .flags(res_flags), .seq_done(seq_done)
  );
endmodule

// File: rtl/conv_seq_sva.sv
`timescale 1ns/1ps
module conv_seq_sva #(
  parameter int CH_W  = 3,
  parameter int IDX_W = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_start,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [CH_W-1:0]       req_ch,
  input logic                  res_valid,
  input logic                  res_ready,
  input logic                  busy,
  input logic                  seq_done,
  input logic [(1<<IDX_W)-1:0] res_flags,
  input logic [IDX_W-1:0]      conv_cnt,
  input logic                  multi_lat
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !wr_start |=> req_valid && $stable(req_ch));

  a_r11_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && res_ready));

  a_r1_channel_step: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !wr_start |=>
      !busy || (req_ch == ($past(multi_lat) ? CH_W'($past(req_ch) + 1'b1) : $past(req_ch))));

  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !wr_start |=> conv_cnt == IDX_W'($past(conv_cnt) + 1'b1));

  a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && !wr_start |=> res_flags[$past(conv_cnt)]);

  a_r6_done_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> $past(res_valid && res_ready));

  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !seq_done && (res_flags == '0));
endmodule

bind conv_seq_ring conv_seq_sva #(.CH_W(CH_W), .IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .req_valid(req_valid),
  .req_ready(req_ready), .req_ch(req_ch), .res_valid(res_valid),
  .res_ready(res_ready), .busy(busy), .seq_done(seq_done),
  .res_flags(res_flags), .conv_cnt(conv_cnt), .multi_lat(multi_lat)
);

// File: tb/sim_conv_seq_ring.sv
`timescale 1ns/1ps
module sim_conv_seq_ring;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [2:0]  cfg_start_ch = '0;
  logic [2:0]  cfg_len = '0;
  logic        cfg_multi = 1'b0, cfg_fifo = 1'b0, cfg_fast_clr = 1'b0;
  logic        cfg_trig_en = 1'b0, cfg_trig_level = 1'b0;
  logic        wr_start = 1'b0, clr_w1c = 1'b0, rd_status = 1'b0, rd_result = 1'b0;
  logic [8:0]  clr_mask = '0;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_data;
  logic        trig_in = 1'b0;
  logic        req_valid, req_ready = 1'b0, conv_abort, res_valid = 1'b0, res_ready;
  logic [2:0]  req_ch;
  logic [15:0] res_data = '0;
  logic        busy, seq_done;
  logic [7:0]  res_flags;
  logic [2:0]  conv_cnt;

  conv_seq_ring u0 (.*);

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  // core model log
  logic [2:0]  lg_ch  [0:63];
  logic [15:0] lg_dat [0:63];
  int lg_n = 0;
  int rs = 0;
  bit resp_on = 1'b1;
  logic [15:0] serial = 16'hC000;
  int model_cnt = 0;

  // {exp_cnt[2:0], fifo, multi, len[2:0], start[2:0]}
  localparam logic [10:0] VEC [6] = '{
    {3'd5, 1'b0, 1'b1, 3'd5, 3'd6},
    {3'd0, 1'b0, 1'b1, 3'd0, 3'd3},
    {3'd3, 1'b0, 1'b0, 3'd3, 3'd2},
    {3'd6, 1'b1, 1'b1, 3'd3, 3'd1},
    {3'd2, 1'b1, 1'b1, 3'd4, 3'd7},
    {3'd1, 1'b0, 1'b1, 3'd1, 3'd0}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter core model
  initial begin
    forever begin
      @(negedge clk);
      if (resp_on) begin
        case (rs)
          0: if (req_valid) begin
               req_ready = 1'b1;
               if (lg_n < 64) lg_ch[lg_n] = req_ch;
               rs = 1;
             end
          1: begin req_ready = 1'b0; rs = 2; end
          2: begin
               serial = serial + 16'd1;
               res_data = serial;
               if (lg_n < 64) lg_dat[lg_n] = serial;
               lg_n++;
               res_valid = 1'b1;
               rs = 3;
             end
          default: begin res_valid = 1'b0; rs = 0; end
        endcase
      end
    end
  end

  task automatic pulse_start();
    @(negedge clk); wr_start = 1'b1;
    @(negedge clk); wr_start = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
  endtask

  task automatic run_seq(input logic [2:0] st, input logic [2:0] ln, input bit mu, input bit ff);
    int n;
    int base;
    logic [7:0] ef;
    cfg_start_ch = st; cfg_len = ln; cfg_multi = mu; cfg_fifo = ff;
    lg_n = 0;
    pulse_start();
    wait_idle();
    n = (ln == 0) ? 8 : int'(ln);
    base = ff ? model_cnt : 0;
    chk(lg_n == n, "R2 conversion count", lg_n, n);
    chk(seq_done == 1'b1, "R6 seq_done after last result", seq_done, 1);
    ef = '0;
    for (int i = 0; i < n; i++) begin
      logic [2:0] ech;
      logic [2:0] dst;
      ech = mu ? 3'(int'(st) + i) : st;
      dst = 3'(base + i);
      ef[dst] = 1'b1;
      chk(lg_ch[i] == ech, "R1 channel order", lg_ch[i], ech);
      rd_idx = dst; #0.1;
      chk(rd_data == lg_dat[i], ff ? "R4 ring destination" : "R3 ring destination", rd_data, lg_dat[i]);
    end
    chk(res_flags == ef, "R6 valid flags", res_flags, ef);
    model_cnt = (base + n) % 8;
    @(negedge clk);
  endtask

  initial begin
    int done_cnt;
    bit prev_done;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk({busy, seq_done, res_flags, conv_cnt, req_valid, res_ready} == '0, "R12 reset state",
        {busy, seq_done, res_flags, conv_cnt, req_valid, res_ready}, 0);

    for (int v = 0; v < 6; v++) begin
      run_seq(VEC[v][2:0], VEC[v][5:3], VEC[v][6], VEC[v][7]);
      chk(conv_cnt == VEC[v][10:8], VEC[v][7] ? "R4 counter persists" : "R3 counter from zero",
          conv_cnt, VEC[v][10:8]);
    end

    // R8 fast-clear off: result read alone leaves flag
    cfg_fast_clr = 1'b0; rd_idx = 3'd0;
    @(negedge clk); rd_result = 1'b1; @(negedge clk); rd_result = 1'b0;
    chk(res_flags[0] == 1'b1, "R8 read without status keeps flag", res_flags[0], 1);
    rd_status = 1'b1; @(negedge clk); rd_status = 1'b0;
    rd_result = 1'b1; @(negedge clk); rd_result = 1'b0;
    chk(res_flags[0] == 1'b0, "R8 status then result clears", res_flags[0], 0);

    // R7 write-1-to-clear
    clr_w1c = 1'b1; clr_mask = 9'h100; @(negedge clk); clr_w1c = 1'b0; clr_mask = '0;
    chk(seq_done == 1'b0, "R7 w1c clears seq_done", seq_done, 0);
    run_seq(3'd0, 3'd2, 1'b1, 1'b0);
    clr_w1c = 1'b1; clr_mask = 9'h002; @(negedge clk); clr_w1c = 1'b0; clr_mask = '0;
    chk(res_flags == 8'h01 && seq_done, "R7 w1c only masked flag", {seq_done, res_flags}, 9'h101);

    // R8 fast-clear on
    cfg_fast_clr = 1'b1; rd_idx = 3'd0;
    rd_result = 1'b1; @(negedge clk); rd_result = 1'b0;
    chk(res_flags == 8'h00, "R8 fast clear by result read", res_flags, 0);
    cfg_fast_clr = 1'b0;

    // R5 abort with outstanding conversion
    resp_on = 1'b0;
    cfg_start_ch = 3'd4; cfg_len = 3'd3; cfg_multi = 1'b1; cfg_fifo = 1'b0;
    pulse_start();
    chk(req_valid && req_ch == 3'd4, "R11 request presented", {req_valid, req_ch}, {1'b1, 3'd4});
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
    chk(res_ready == 1'b1 && req_valid == 1'b0, "R11 awaiting result", {req_valid, res_ready}, 2'b01);
    cfg_start_ch = 3'd5; cfg_len = 3'd2; wr_start = 1'b1; #0.1;
    chk(conv_abort == 1'b1, "R5 abort pulse", conv_abort, 1);
    @(negedge clk); wr_start = 1'b0;
    chk(req_valid && req_ch == 3'd5 && conv_cnt == 3'd0 && res_flags == 8'h00 && !seq_done,
        "R5 restart state", {req_valid, req_ch, conv_cnt, res_flags, seq_done}, {1'b1, 3'd5, 3'd0, 8'h00, 1'b0});
    lg_n = 0; rs = 0; resp_on = 1'b1;
    wait_idle();
    chk(lg_n == 2 && lg_ch[0] == 3'd5 && lg_ch[1] == 3'd6, "R5 new sequence channels",
        {lg_n[3:0], lg_ch[0], lg_ch[1]}, {4'd2, 3'd5, 3'd6});
    model_cnt = 2;

    // R9 edge trigger
    cfg_start_ch = 3'd3; cfg_len = 3'd1; cfg_fifo = 1'b0;
    cfg_trig_en = 1'b1; cfg_trig_level = 1'b0;
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R9 edge starts sequence", busy, 1);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(busy == 1'b0 && seq_done == 1'b1, "R9 held level does not restart", {busy, seq_done}, 2'b01);
    trig_in = 1'b0;

    // R10 level trigger
    cfg_trig_level = 1'b1; done_cnt = 0; prev_done = seq_done;
    @(negedge clk); trig_in = 1'b1;
    for (int t = 0; t < 300 && done_cnt < 3; t++) begin
      @(negedge clk);
      if (seq_done && !prev_done) done_cnt++;
      prev_done = seq_done;
    end
    trig_in = 1'b0;
    chk(done_cnt >= 3, "R10 level repeats sequences", done_cnt, 3);
    wait_idle();
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R10 stops after level drops", busy, 0);
    cfg_trig_en = 1'b0;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule